// File: doc/BRIEF.md
# Two-phase data-cache access requester

This block is the load/store-side master for a data-cache port on which every access travels in two phases. In the first phase the set index, the write data, the write flag and the byte enables are driven together with a request strobe, and they stay put until the cache grants. In the cycle after the grant the second phase begins: the tag is driven with a tag-valid strobe and held until the cache answers with a response strobe. That strobe comes for stores as well as loads. For a store it only releases the tag.

Commands enter through a valid/ready interface that carries the index and tag already split. Load data returns on a one-cycle response strobe in the same cycle the cache answers. Up to two granted accesses may wait for their answers. A small in-order queue pairs each answer with its tag, its load/store type and an abort mark. While one access is in its tag phase, the abort input makes the block raise the cache kill line for one cycle. The answer to that access is then thrown away. At the same time the index phase can already carry the next request.

Top module: `ixt_requester`

## Requirements
- R1: Out of reset, `cache_req`, `cache_tag_valid`, `cache_kill` and `rsp_valid` are low and `cmd_ready` is high.
- R2: While `cache_req` is high and `cache_gnt` is low, `cache_req` stays high in the next cycle and `cache_index`, `cache_wdata`, `cache_we` and `cache_be` keep their values. A grant may come in the first cycle of a request or any number of cycles later.
- R3: An accepted command is driven on the index phase in the cycle after acceptance. With the cache granting at once, the access accepted k-th (counting from 0 at cycle 0) is granted in cycle k+1.
- R4: The tag of a granted access appears on `cache_tag` with `cache_tag_valid` high in the cycle after its grant. Both stay unchanged until a cycle with `cache_rvalid` high. Tags are presented in grant order.
- R5: No more than 2 granted accesses are ever waiting for `cache_rvalid`. `cmd_ready` is low whenever accepting would exceed this count.
- R6: When grants and answers are immediate, one access completes per cycle. The answer for access k arrives in cycle k+2, in the same cycle its tag is first presented.
- R7: In a cycle with `cache_rvalid` high for a load that was not aborted, `rsp_valid` is high and `rsp_rdata` equals `cache_rdata`. A store (`cmd_we`=1) or an aborted access never raises `rsp_valid`, and `rsp_valid` is never high without `cache_rvalid`.
- R8: `abort_req` while `cache_tag_valid` is high raises `cache_kill` in that same cycle, at most once per access. The answer to that access is discarded, even when it arrives in the kill cycle. `abort_req` with no access in its tag phase has no effect.
- R9: A new request may be granted on the index phase in the same cycle that `cache_kill` is high for the access in its tag phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Upstream command present |
| cmd_ready | output | 1 | Block takes the command this cycle |
| cmd_we | input | 1 | 1 = store, 0 = load |
| cmd_index | input | 12 | Set index of the access |
| cmd_tag | input | 44 | Tag of the access |
| cmd_wdata | input | 64 | Store data |
| cmd_be | input | 8 | Store byte enables |
| abort_req | input | 1 | Abandon the access now in its tag phase |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 64 | Load data |
| cache_req | output | 1 | Index-phase request strobe |
| cache_index | output | 12 | Index to the cache |
| cache_wdata | output | 64 | Write data to the cache |
| cache_we | output | 1 | Access is a write |
| cache_be | output | 8 | Byte enables to the cache |
| cache_gnt | input | 1 | Cache took the index phase |
| cache_tag | output | 44 | Tag to the cache |
| cache_tag_valid | output | 1 | Tag-phase strobe |
| cache_kill | output | 1 | Kill the access in its tag phase |
| cache_rvalid | input | 1 | Cache answer for the access in its tag phase |
| cache_rdata | input | 64 | Read data from the cache |

## Verification
The bench builds the block with its default widths and an in-flight depth of 2. It sweeps every pairing of grant delay and answer delay from 0 to 3 cycles over bursts of eight mixed loads and stores. Each burst aborts a rotating set of accesses. The zero-delay pairing makes the exact one-per-cycle timing checkable. The slow-answer pairings fill the in-flight queue, so back-pressure on `cmd_ready` is exercised. Between them they also reach aborts that land in the answer cycle and aborts that overlap a new grant.

// File: rtl/ixt_pkg.sv
package ixt_pkg;

  // Per-access bookkeeping held while an access waits in its tag phase.
  typedef struct packed {
    logic is_store;
    logic dropped;
  } flight_flags_t;

endpackage

// File: rtl/ixt_req_stage.sv
// Index-phase holding register: one access, held until the cache grants it.
module ixt_req_stage #(
  parameter int IDX_W  = 12,
  parameter int TAG_W  = 44,
  parameter int DATA_W = 64,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              in_we,
  input  logic [IDX_W-1:0]  in_index,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [BE_W-1:0]   in_be,
  input  logic              gnt,
  output logic              busy,
  output logic              out_we,
  output logic [IDX_W-1:0]  out_index,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_wdata,
  output logic [BE_W-1:0]   out_be
);

  logic busy_q, busy_d;

  always_comb begin
    busy_d = busy_q;
    if (load)
      busy_d = 1'b1;
    else if (gnt)
      busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_q <= 1'b0;
    else
      busy_q <= busy_d;
  end

  // Payload registers: clock-enabled, no reset needed.
  always_ff @(posedge clk) begin
    if (load) begin
      out_we    <= in_we;
      out_index <= in_index;
      out_tag   <= in_tag;
      out_wdata <= in_wdata;
      out_be    <= in_be;
    end
  end

  assign busy = busy_q;

  // R2: a pending request is held, with its payload, until granted.
  a_r2_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !gnt |=> busy_q && $stable(out_index) && $stable(out_wdata)
                        && $stable(out_we) && $stable(out_be));

endmodule

// File: rtl/ixt_inflight_q.sv
// In-order queue of granted accesses waiting for their cache answer.
module ixt_inflight_q
  import ixt_pkg::*;
#(
  parameter int TAG_W = 44,
  parameter int DEPTH = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [TAG_W-1:0]               push_tag,
  input  logic                           push_store,
  input  logic                           pop,
  input  logic                           mark_drop,
  output logic                           head_valid,
  output logic [TAG_W-1:0]               head_tag,
  output flight_flags_t                  head_flags,
  output logic [$clog2(DEPTH+1)-1:0]     count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] tag_q [DEPTH];
  flight_flags_t    flg_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push)
      wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)
      rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop)
      cnt_d = cnt_q + 1'b1;
    else if (pop && !push)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic          wr_hit;
    flight_flags_t flg_d;

    assign wr_hit = push && (wr_q == PTR_W'(s));

    always_comb begin
      flg_d = flg_q[s];
      if (wr_hit) begin
        flg_d.is_store = push_store;
        flg_d.dropped  = 1'b0;
      end else if (mark_drop && (rd_q == PTR_W'(s))) begin
        flg_d.dropped = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flg_q[s] <= '0;
      else
        flg_q[s] <= flg_d;
    end

    always_ff @(posedge clk) begin
      if (wr_hit)
        tag_q[s] <= push_tag;
    end
  end

  assign head_valid = (cnt_q != '0);
  assign head_tag   = tag_q[rd_q];
  assign head_flags = flg_q[rd_q];
  assign count      = cnt_q;

  // R5: a grant never lands on a full queue.
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < CNT_W'(DEPTH)));

  // R5: occupancy stays within the configured depth.
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/ixt_requester.sv
// Two-phase (index, then tag) data-cache requester.
module ixt_requester
  import ixt_pkg::*;
#(
  parameter int IDX_W    = 12,
  parameter int TAG_W    = 44,
  parameter int DATA_W   = 64,
  parameter int BE_W     = DATA_W / 8,
  parameter int INFLIGHT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [BE_W-1:0]   cmd_be,
  input  logic              abort_req,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              cache_req,
  output logic [IDX_W-1:0]  cache_index,
  output logic [DATA_W-1:0] cache_wdata,
  output logic              cache_we,
  output logic [BE_W-1:0]   cache_be,
  input  logic              cache_gnt,
  output logic [TAG_W-1:0]  cache_tag,
  output logic              cache_tag_valid,
  output logic              cache_kill,
  input  logic              cache_rvalid,
  input  logic [DATA_W-1:0] cache_rdata
);

  localparam int CNT_W = $clog2(INFLIGHT + 1);
  localparam int SUM_W = CNT_W + 1;

  logic             stg_busy;
  logic [TAG_W-1:0] stg_tag;
  logic             take_cmd;
  logic             granted;
  logic             answered;
  logic             drop_now;
  logic             head_valid;
  logic [TAG_W-1:0] head_tag;
  flight_flags_t    head_flags;
  logic [CNT_W-1:0] q_count;
  logic [SUM_W-1:0] committed;

  // Slots already claimed after this cycle: queued accesses plus the one
  // waiting for a grant, minus the one answered now.
  always_comb begin
    committed = SUM_W'(q_count) + SUM_W'(stg_busy) - SUM_W'(answered);
    cmd_ready = (!stg_busy || cache_gnt) && (committed < SUM_W'(INFLIGHT));
  end

  assign take_cmd = cmd_valid && cmd_ready;
  assign granted  = stg_busy && cache_gnt;
  assign answered = cache_rvalid && head_valid;

  ixt_req_stage #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W),
    .DATA_W(DATA_W),
    .BE_W  (BE_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_cmd),
    .in_we    (cmd_we),
    .in_index (cmd_index),
    .in_tag   (cmd_tag),
    .in_wdata (cmd_wdata),
    .in_be    (cmd_be),
    .gnt      (cache_gnt),
    .busy     (stg_busy),
    .out_we   (cache_we),
    .out_index(cache_index),
    .out_tag  (stg_tag),
    .out_wdata(cache_wdata),
    .out_be   (cache_be)
  );

  ixt_inflight_q #(
    .TAG_W(TAG_W),
    .DEPTH(INFLIGHT)
  ) u_flight (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (granted),
    .push_tag  (stg_tag),
    .push_store(cache_we),
    .pop       (answered),
    .mark_drop (cache_kill),
    .head_valid(head_valid),
    .head_tag  (head_tag),
    .head_flags(head_flags),
    .count     (q_count)
  );

  assign cache_req       = stg_busy;
  assign cache_tag       = head_tag;
  assign cache_tag_valid = head_valid;
  assign cache_kill      = abort_req && head_valid && !head_flags.dropped;
  assign drop_now        = head_flags.dropped || cache_kill;
  assign rsp_valid       = answered && !head_flags.is_store && !drop_now;
  assign rsp_rdata       = cache_rdata;

  // R4: the tag phase is held until the cache answers.
  a_r4_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cache_tag_valid && !cache_rvalid |=> cache_tag_valid && $stable(cache_tag));

  // R4: a grant always opens a tag phase in the following cycle.
  a_r4_tag_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req && cache_gnt |=> cache_tag_valid);

  // R7: load data only leaves with a cache answer.
  a_r7_rsp_needs_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cache_rvalid && cache_tag_valid);

  // R8: kill only in the tag phase.
  a_r8_kill_in_tag_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cache_kill |-> cache_tag_valid);

  // R8: one kill per access while it stays in its tag phase.
  a_r8_single_kill: assert property (@(posedge clk) disable iff (!rst_n)
    cache_kill && !cache_rvalid |=> !cache_kill);

endmodule

// File: tb/ixt_requester_tb.sv
`timescale 1ns/1ps
module ixt_requester_tb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_ready, cmd_we;
  logic [11:0] cmd_index;
  logic [43:0] cmd_tag;
  logic [63:0] cmd_wdata;
  logic [7:0]  cmd_be;
  logic        abort_req, rsp_valid;
  logic [63:0] rsp_rdata;
  logic        cache_req, cache_we, cache_gnt, cache_tag_valid, cache_kill, cache_rvalid;
  logic [11:0] cache_index;
  logic [63:0] cache_wdata, cache_rdata;
  logic [7:0]  cache_be;
  logic [43:0] cache_tag;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ixt_requester u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_we(cmd_we),
    .cmd_index(cmd_index), .cmd_tag(cmd_tag), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .abort_req(abort_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cache_req(cache_req), .cache_index(cache_index), .cache_wdata(cache_wdata),
    .cache_we(cache_we), .cache_be(cache_be), .cache_gnt(cache_gnt),
    .cache_tag(cache_tag), .cache_tag_valid(cache_tag_valid), .cache_kill(cache_kill),
    .cache_rvalid(cache_rvalid), .cache_rdata(cache_rdata)
  );

  function automatic logic [11:0] idx_f(int k);
    return 12'(k * 37 + 5);
  endfunction
  function automatic logic [43:0] tag_f(int k);
    return 44'(64'h0ABC_0000_0000 ^ (64'(k) * 64'h1_0001_0003));
  endfunction
  function automatic logic [63:0] wd_f(int k);
    return {32'hDEAD_0000 ^ 32'(k), 32'hBEEF_0000 | 32'(k)};
  endfunction
  function automatic logic [7:0] be_f(int k);
    return 8'(k * 29 + 1);
  endfunction
  function automatic logic we_f(int k);
    return (k % 3) == 1;
  endfunction
  function automatic logic kill_f(int k, int run);
    return ((k + run) % 4) == 2;
  endfunction
  function automatic logic [63:0] rd_f(logic [43:0] t);
    return {20'hFACE0, t} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", what, got, exp);
    end
  endtask

  initial begin
    int gd, rd, sent, iss, rsp, gcnt, rcnt, cyc;
    bit seen_kill_grant;
    bit exp_rsp;
    seen_kill_grant = 0;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_we = 0; cmd_index = '0; cmd_tag = '0; cmd_wdata = '0; cmd_be = '0;
    abort_req = 0; cache_gnt = 0; cache_rvalid = 0; cache_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cache_req == 0, "R1 cache_req", 64'(cache_req), 0);
    chk(cache_tag_valid == 0, "R1 tag_valid", 64'(cache_tag_valid), 0);
    chk(rsp_valid == 0, "R1 rsp_valid", 64'(rsp_valid), 0);
    chk(cmd_ready == 1, "R1 cmd_ready", 64'(cmd_ready), 1);
    // R8: abort with nothing in tag phase is ignored
    abort_req = 1;
    #1;
    chk(cache_kill == 0, "R8 idle abort kill", 64'(cache_kill), 0);
    @(negedge clk);
    abort_req = 0;
    chk(cache_tag_valid == 0, "R8 idle abort state", 64'(cache_tag_valid), 0);

    for (int run = 0; run < 16; run++) begin
      gd = run / 4; rd = run % 4;
      sent = 0; iss = 0; rsp = 0; gcnt = 0; rcnt = 0; cyc = 0;
      while (rsp < N && cyc < 400) begin
        cmd_valid = (sent < N);
        cmd_we = we_f(sent); cmd_index = idx_f(sent); cmd_tag = tag_f(sent);
        cmd_wdata = wd_f(sent); cmd_be = be_f(sent);
        cache_gnt = cache_req && (gcnt == gd);
        cache_rvalid = cache_tag_valid && (rcnt == rd);
        cache_rdata = rd_f(tag_f(rsp));
        abort_req = cache_tag_valid && (rcnt == 0) && kill_f(rsp, run);
        #1;
        if (cache_req) begin
          chk(cache_index == idx_f(iss), "R2 index", 64'(cache_index), 64'(idx_f(iss)));
          chk(cache_wdata == wd_f(iss), "R2 wdata", cache_wdata, wd_f(iss));
          chk(cache_we == we_f(iss), "R2 we", 64'(cache_we), 64'(we_f(iss)));
          chk(cache_be == be_f(iss), "R2 be", 64'(cache_be), 64'(be_f(iss)));
        end
        if (cache_tag_valid)
          chk(cache_tag == tag_f(rsp), "R4 tag", 64'(cache_tag), 64'(tag_f(rsp)));
        chk(cache_kill == abort_req, "R8 kill", 64'(cache_kill), 64'(abort_req));
        chk((iss - rsp) <= 2, "R5 outstanding", 64'(iss - rsp), 2);
        if (cache_rvalid) begin
          exp_rsp = !we_f(rsp) && !kill_f(rsp, run);
          chk(rsp_valid == exp_rsp, "R7 rsp_valid", 64'(rsp_valid), 64'(exp_rsp));
          if (exp_rsp)
            chk(rsp_rdata == rd_f(tag_f(rsp)), "R7 rdata", rsp_rdata, rd_f(tag_f(rsp)));
          if (gd == 0 && rd == 0)
            chk(cyc == rsp + 2, "R6 answer cycle", 64'(cyc), 64'(rsp + 2));
        end else begin
          chk(rsp_valid == 0, "R7 no answer", 64'(rsp_valid), 0);
        end
        if (cache_gnt && gd == 0 && rd == 0)
          chk(cyc == iss + 1, "R3 grant cycle", 64'(cyc), 64'(iss + 1));
        if (cache_kill && cache_gnt) seen_kill_grant = 1;
        if (cache_gnt) begin iss++; gcnt = 0; end
        else if (cache_req) gcnt++;
        if (cache_rvalid) begin rsp++; rcnt = 0; end
        else if (cache_tag_valid) rcnt++;
        if (cmd_valid && cmd_ready) sent++;
        @(negedge clk);
        cyc++;
      end
      if (rsp < N) begin
        checks++; failures++;
        $display("FAIL watchdog run=%0d got=%0d exp=%0d", run, rsp, N);
      end
      cmd_valid = 0; cache_gnt = 0; cache_rvalid = 0; abort_req = 0;
      @(negedge clk);
      chk(cache_req == 0 && cache_tag_valid == 0, "R4 idle after burst",
          64'({cache_req, cache_tag_valid}), 0);
    end
    chk(seen_kill_grant, "R9 kill with grant", 64'(seen_kill_grant), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule